// File: doc/BRIEF.md
# Sector Hamming Code Checker and Single-Bit Repairer

This block judges one 512-byte sector after it has been read back from storage. It receives two 3-byte single-error-correcting codes: the one saved alongside the sector when it was written, and the one recomputed over the data just read. The two codes are rearranged into a 32-bit form in which the upper half carries the error location and the lower half carries its complement. The block XORs the two and decides the outcome from the number of set bits in the result.

There are five possible outcomes. When both codes agree, the sector is clean. A saved code of all ones set against a computed code of all zeros marks a sector that was never written, and this is also reported as clean. When exactly twelve bits differ, one data bit has flipped; the block locates it and repairs it in place. It does this through a byte-wide port into the sector buffer: it reads the byte, waits one cycle, and writes the byte back with the bit inverted. When exactly one bit differs, the saved code itself is damaged and the data is left alone. Every other difference is reported as uncorrectable.

The block has no data stream of its own, so every pin is a plain control or status signal. A start pulse that arrives while a check is still running is dropped, and nothing pushes back on the sender. The caller waits for the done pulse before it issues the next start.

Top module: `sector_ecc_fixer`

## Requirements
- R1: Each 3-byte code (byte k on bits 8k+7:8k of its port) is rearranged into 32 bits as follows. Byte 0 goes to bits 7:0 and byte 1 to bits 23:16. The low nibble of byte 2 goes to bits 11:8 and its high nibble to bits 27:24. All other bits are zero.
- R2: If the rearranged codes are equal, status is 0 (clean) and the sector buffer is neither read nor written.
- R3: If their XOR has exactly 12 set bits, status is 1 (corrected). `fix_bit` is XOR bits 18:16 and `fix_byte` is XOR bits 27:19. When status is not 1, both location outputs read zero.
- R4: On a correction, exactly one read and one write go to the addressed byte. The byte written back differs from the byte read in exactly the bit named by `fix_bit`, and no other sector byte changes.
- R5: If the XOR has exactly one set bit, status is 2 (code corrupt) and the buffer is not written.
- R6: If the rearranged saved code is 0x0FFF0FFF and the rearranged computed code is zero, status is 0 (erased sector) with no buffer access.
- R7: Any other non-zero XOR gives status 3 (uncorrectable) with no buffer write.
- R8: Timing is counted in rising edges after the edge that samples `start`. Without a correction, `done` rises after the 1st edge. With a correction, the read request is high after the 1st edge, the write after the 3rd, and `done` after the 4th. `done`, the read request and the write enable each last one cycle.
- R9: A `start` that arrives while a check is in progress is ignored. The running result and its write-back are unaffected, and no extra `done` follows.
- R10: After reset, `done`, the read request and the write enable are low, and status and location are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a check using the codes present on this cycle |
| stored_code | input | 24 | Code saved with the sector |
| calc_code | input | 24 | Code recomputed over the sector as read |
| done | output | 1 | One-cycle pulse; result outputs are valid from here |
| status | output | 2 | 0 clean, 1 corrected, 2 code corrupt, 3 uncorrectable |
| fix_byte | output | 9 | Repaired byte index (zero unless status is 1) |
| fix_bit | output | 3 | Repaired bit index (zero unless status is 1) |
| buf_rd_req | output | 1 | Sector buffer read request |
| buf_rd_addr | output | 9 | Sector buffer read address |
| buf_rd_data | input | 8 | Read data, valid the cycle after the request is sampled |
| buf_wr_en | output | 1 | Sector buffer write enable |
| buf_wr_addr | output | 9 | Sector buffer write address |
| buf_wr_data | output | 8 | Repaired byte |

## Verification
A check that needs no repair completes one edge after `start` is sampled, and a repair completes four edges after. The bench counts the edges from the start edge until `done` appears, samples on falling edges, and compares that count with 1 or 4 according to the expected status. It then checks on the following falling edge that `done` has dropped. Buffer reads and writes are counted as the modelled buffer samples them, and the whole sector is compared only after `done`, when the write-back has landed.

// File: rtl/secc_pkg.sv
package secc_pkg;
  localparam int SECTOR_BYTES = 512;
  localparam int BYTE_W       = 8;
  localparam int ADDR_W       = $clog2(SECTOR_BYTES);
  localparam int BIT_W        = $clog2(BYTE_W);
  localparam int CODE_BYTES   = 3;
  localparam int CODE_W       = CODE_BYTES * BYTE_W;
  localparam int PACK_W       = 32;
  localparam int HALF_W       = PACK_W / 2;
  localparam int CNT_W        = $clog2(PACK_W + 1);
  localparam int LOC_W        = ADDR_W + BIT_W;
  localparam logic [PACK_W-1:0] ERASED_PACK = 32'h0FFF_0FFF;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_EBAD  = 2'd2,
    ST_MULTI = 2'd3
  } ecc_status_e;

  typedef enum logic [2:0] {
    F_IDLE, F_EVAL, F_READ, F_WAIT, F_WRITE
  } fix_state_e;
endpackage

// File: rtl/secc_pack.sv
module secc_pack
  import secc_pkg::*;
#(
  parameter int IN_W  = CODE_W,
  parameter int OUT_W = PACK_W
) (
  input  logic [IN_W-1:0]  code_i,
  output logic [OUT_W-1:0] pack_o
);
  localparam int NIB = BYTE_W / 2;

  // R1: byte 0 -> low byte of low half, byte 1 -> low byte of high half,
  // byte 2 split by nibble into the byte above each of those.
  always_comb begin
    pack_o = '0;
    pack_o[0 +: BYTE_W]               = code_i[0 +: BYTE_W];
    pack_o[HALF_W +: BYTE_W]          = code_i[BYTE_W +: BYTE_W];
    pack_o[BYTE_W +: NIB]             = code_i[2*BYTE_W +: NIB];
    pack_o[HALF_W + BYTE_W +: NIB]    = code_i[2*BYTE_W + NIB +: NIB];
  end
endmodule

// File: rtl/secc_classify.sv
module secc_classify
  import secc_pkg::*;
#(
  parameter int W       = PACK_W,
  parameter int A_W     = ADDR_W,
  parameter int B_W     = BIT_W,
  parameter int PAIRS   = LOC_W
) (
  input  logic [W-1:0]   stored_p_i,
  input  logic [W-1:0]   calc_p_i,
  output ecc_status_e    cls_o,
  output logic [A_W-1:0] byte_o,
  output logic [B_W-1:0] bit_o
);
  localparam int LOC_LSB = W / 2;
  localparam int C_W     = $clog2(W + 1);

  logic [W-1:0]   diff;
  logic [C_W-1:0] ones;

  assign diff = stored_p_i ^ calc_p_i;

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) ones = ones + C_W'(diff[i]);
  end

  // R3: location taken from the upper half of the difference
  assign bit_o  = diff[LOC_LSB +: B_W];
  assign byte_o = diff[LOC_LSB + B_W +: A_W];

  // R2 R3 R5 R6 R7
  always_comb begin
    if (diff == '0)                                   cls_o = ST_CLEAN;
    else if (ones == C_W'(PAIRS))                     cls_o = ST_FIXED;
    else if (ones == C_W'(1))                         cls_o = ST_EBAD;
    else if (stored_p_i == ERASED_PACK && calc_p_i == '0) cls_o = ST_CLEAN;
    else                                              cls_o = ST_MULTI;
  end
endmodule

// File: rtl/secc_flip_ctl.sv
module secc_flip_ctl
  import secc_pkg::*;
#(
  parameter int A_W = ADDR_W,
  parameter int D_W = BYTE_W,
  parameter int B_W = BIT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  ecc_status_e    cls_i,
  input  logic [A_W-1:0] byte_i,
  input  logic [B_W-1:0] bit_i,
  output logic           accept_o,
  output logic           done_o,
  output ecc_status_e    status_o,
  output logic [A_W-1:0] fix_byte_o,
  output logic [B_W-1:0] fix_bit_o,
  output logic           rd_req_o,
  output logic [A_W-1:0] rd_addr_o,
  input  logic [D_W-1:0] rd_data_i,
  output logic           wr_en_o,
  output logic [A_W-1:0] wr_addr_o,
  output logic [D_W-1:0] wr_data_o
);
  fix_state_e     state;
  logic [A_W-1:0] tgt_byte;
  logic [B_W-1:0] tgt_bit;

  // R9: new work is taken only when idle
  assign accept_o = start_i && (state == F_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= F_IDLE;
      tgt_byte   <= '0;
      tgt_bit    <= '0;
      done_o     <= 1'b0;
      status_o   <= ST_CLEAN;
      fix_byte_o <= '0;
      fix_bit_o  <= '0;
      rd_req_o   <= 1'b0;
      rd_addr_o  <= '0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      done_o   <= 1'b0;
      rd_req_o <= 1'b0;
      wr_en_o  <= 1'b0;
      unique case (state)
        F_IDLE: if (start_i) state <= F_EVAL;
        F_EVAL: begin
          if (cls_i == ST_FIXED) begin
            tgt_byte  <= byte_i;
            tgt_bit   <= bit_i;
            rd_req_o  <= 1'b1;
            rd_addr_o <= byte_i;
            state     <= F_READ;
          end else begin
            status_o   <= cls_i;
            fix_byte_o <= '0;
            fix_bit_o  <= '0;
            done_o     <= 1'b1;
            state      <= F_IDLE;
          end
        end
        F_READ: state <= F_WAIT;
        F_WAIT: begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= tgt_byte;
          wr_data_o <= rd_data_i ^ (D_W'(1) << tgt_bit);
          state     <= F_WRITE;
        end
        F_WRITE: begin
          status_o   <= ST_FIXED;
          fix_byte_o <= tgt_byte;
          fix_bit_o  <= tgt_bit;
          done_o     <= 1'b1;
          state      <= F_IDLE;
        end
        default: state <= F_IDLE;
      endcase
    end
  end

  a_r8_read_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);
  a_r8_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(rd_req_o, 2));
  a_r4_same_byte: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> wr_addr_o == $past(rd_addr_o, 2));
  a_r4_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $countones(wr_data_o ^ $past(rd_data_i)) == 1);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r3_loc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_o != ST_FIXED |-> (fix_byte_o == '0 && fix_bit_o == '0));
  a_r4_fixed_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == ST_FIXED) |-> $past(wr_en_o));
endmodule

// File: rtl/sector_ecc_fixer.sv
module sector_ecc_fixer
  import secc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CODE_W-1:0]   stored_code,
  input  logic [CODE_W-1:0]   calc_code,
  output logic                done,
  output logic [1:0]          status,
  output logic [ADDR_W-1:0]   fix_byte,
  output logic [BIT_W-1:0]    fix_bit,
  output logic                buf_rd_req,
  output logic [ADDR_W-1:0]   buf_rd_addr,
  input  logic [BYTE_W-1:0]   buf_rd_data,
  output logic                buf_wr_en,
  output logic [ADDR_W-1:0]   buf_wr_addr,
  output logic [BYTE_W-1:0]   buf_wr_data
);
  localparam int NCODES = 2;

  logic [CODE_W-1:0] codes_in [NCODES];
  logic [PACK_W-1:0] packed_in [NCODES];
  logic [PACK_W-1:0] packed_q  [NCODES];
  logic              accept;
  ecc_status_e       cls;
  ecc_status_e       st_q;
  logic [ADDR_W-1:0] loc_byte;
  logic [BIT_W-1:0]  loc_bit;

  assign codes_in[0] = stored_code;
  assign codes_in[1] = calc_code;

  for (genvar g = 0; g < NCODES; g++) begin : g_pack
    secc_pack u_pack (.code_i(codes_in[g]), .pack_o(packed_in[g]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      packed_q[g] <= '0;
      else if (accept) packed_q[g] <= packed_in[g];
    end
  end

  secc_classify u_cls (
    .stored_p_i (packed_q[0]),
    .calc_p_i   (packed_q[1]),
    .cls_o      (cls),
    .byte_o     (loc_byte),
    .bit_o      (loc_bit)
  );

  secc_flip_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .cls_i      (cls),
    .byte_i     (loc_byte),
    .bit_i      (loc_bit),
    .accept_o   (accept),
    .done_o     (done),
    .status_o   (st_q),
    .fix_byte_o (fix_byte),
    .fix_bit_o  (fix_bit),
    .rd_req_o   (buf_rd_req),
    .rd_addr_o  (buf_rd_addr),
    .rd_data_i  (buf_rd_data),
    .wr_en_o    (buf_wr_en),
    .wr_addr_o  (buf_wr_addr),
    .wr_data_o  (buf_wr_data)
  );

  assign status = st_q;

  // R5 R7: no write reaches the buffer for a result other than a repair
  a_r5_no_write_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != 2'd1) |-> !$past(buf_wr_en));
  // R9: captured codes move only on an accepted start
  a_r9_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !accept) |=> $stable(packed_q[0]) && $stable(packed_q[1]));
endmodule

// File: tb/sector_ecc_fixer_test.sv
`timescale 1ns/1ps
module sector_ecc_fixer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] stored = '0, calc = '0;
  logic done, buf_rd_req, buf_wr_en;
  logic [1:0] status;
  logic [8:0] fix_byte, buf_rd_addr, buf_wr_addr;
  logic [2:0] fix_bit;
  logic [7:0] buf_rd_data = '0, buf_wr_data;
  logic [7:0] mem [512];
  int rd_cnt = 0, wr_cnt = 0;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  sector_ecc_fixer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .stored_code(stored), .calc_code(calc),
    .done(done), .status(status), .fix_byte(fix_byte), .fix_bit(fix_bit),
    .buf_rd_req(buf_rd_req), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
    .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data));

  // sector buffer model: registered read, synchronous write
  always @(posedge clk) begin
    if (buf_rd_req) begin
      buf_rd_data <= mem[buf_rd_addr];
      rd_cnt = rd_cnt + 1;
    end
    if (buf_wr_en) begin
      mem[buf_wr_addr] <= buf_wr_data;
      wr_cnt = wr_cnt + 1;
    end
  end

  // {stored, calc, status, byte, bit, pad}
  localparam logic [63:0] VECS [12] = '{
    {24'h123456, 24'h123456, 2'd0, 9'd0,   3'd0, 2'b0},
    {24'h5A2BD4, 24'h000000, 2'd1, 9'd165, 3'd3, 2'b0},
    {24'h3C00A5, 24'hCCFFA5, 2'd1, 9'd511, 3'd7, 2'b0},
    {24'h0F00FF, 24'h000000, 2'd1, 9'd0,   3'd0, 2'b0},
    {24'h000FFF, 24'h000000, 2'd1, 9'd1,   3'd7, 2'b0},
    {24'h000010, 24'h000000, 2'd2, 9'd0,   3'd0, 2'b0},
    {24'h800000, 24'h000000, 2'd2, 9'd0,   3'd0, 2'b0},
    {24'hFFFFFF, 24'h000000, 2'd0, 9'd0,   3'd0, 2'b0},
    {24'hFFFFFF, 24'h000001, 2'd3, 9'd0,   3'd0, 2'b0},
    {24'h000003, 24'h000000, 2'd3, 9'd0,   3'd0, 2'b0},
    {24'h0007FF, 24'h000000, 2'd3, 9'd0,   3'd0, 2'b0},
    {24'h000000, 24'hFFFFFF, 2'd3, 9'd0,   3'd0, 2'b0}
  };

  function automatic logic [7:0] pat(int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  function automatic string tag(logic [1:0] s);
    case (s)
      2'd0: return "R2/R6";
      2'd1: return "R3";
      2'd2: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 512; i++) mem[i] = pat(i);
    rd_cnt = 0;
    wr_cnt = 0;
  endtask

  task automatic mem_chk(input logic [1:0] es, input logic [8:0] eb, input logic [2:0] ek);
    int errs = 0;
    for (int i = 0; i < 512; i++) begin
      logic [7:0] e = pat(i);
      if (es == 2'd1 && i == int'(eb)) e = e ^ (8'd1 << ek);
      if (mem[i] !== e) errs++;
    end
    chk(errs == 0, "R4", "sector bytes wrong", errs, 0);
  endtask

  task automatic run_vec(input logic [23:0] st, input logic [23:0] cp,
                         input logic [1:0] es, input logic [8:0] eb, input logic [2:0] ek);
    int lat = 0;
    fill();
    @(negedge clk);
    stored = st; calc = cp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    chk(lat == ((es == 2'd1) ? 4 : 1), "R8", "done latency", lat, (es == 2'd1) ? 4 : 1);
    chk(status == es, tag(es), "status", status, es);
    chk(fix_byte == eb && fix_bit == ek, "R1/R3", "location", {fix_byte, fix_bit}, {eb, ek});
    chk(rd_cnt == ((es == 2'd1) ? 1 : 0), "R2/R4", "buffer reads", rd_cnt, (es == 2'd1) ? 1 : 0);
    chk(wr_cnt == ((es == 2'd1) ? 1 : 0), "R4/R5/R7", "buffer writes", wr_cnt, (es == 2'd1) ? 1 : 0);
    @(negedge clk);
    chk(!done, "R8", "done width", done, 0);
    mem_chk(es, eb, ek);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    fill();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!done && !buf_rd_req && !buf_wr_en, "R10", "controls in reset", {done, buf_rd_req, buf_wr_en}, 0);
    chk(status == 2'd0 && fix_byte == 9'd0 && fix_bit == 3'd0, "R10", "result in reset", {status, fix_byte, fix_bit}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && wr_cnt == 0 && rd_cnt == 0, "R10", "idle after reset", {done, 8'(wr_cnt)}, 0);

    for (int v = 0; v < 12; v++) begin
      logic [63:0] e = VECS[v];
      run_vec(e[63:40], e[39:16], e[15:14], e[13:5], e[4:2]);
    end

    // R9: second start during a repair is dropped
    begin
      int lat = 0;
      int dones = 0;
      fill();
      @(negedge clk);
      stored = 24'h5A2BD4; calc = 24'h000000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      stored = 24'h000010; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && lat < 40) begin @(negedge clk); lat++; end
      chk(status == 2'd1 && fix_byte == 9'd165 && fix_bit == 3'd3, "R9", "result kept",
          {status, fix_byte, fix_bit}, {2'd1, 9'd165, 3'd3});
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        if (done) dones++;
      end
      chk(dones == 0, "R9", "extra done", dones, 0);
      chk(wr_cnt == 1 && status == 2'd1, "R9", "writes", wr_cnt, 1);
      mem_chk(2'd1, 9'd165, 3'd3);
    end

    // R3: location clears once a non-repair result follows a repair
    run_vec(24'h000003, 24'h000000, 2'd3, 9'd0, 3'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule